// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block folds every interrupt source of an audio controller into one 32-bit status word and one level-sensitive interrupt request line. The sources are a response-ring status/control pair, a vector of codec state-change flags with matching wake enables, and one status/control pair per stream. Streams are indexed with the input streams first and the output streams after them. The aggregator gives every stream index the same treatment whatever its direction.

A global control word supplies three kinds of enable: a global interrupt enable, a controller enable and one enable per stream. The status word is rebuilt from its sources on every clock and does not depend on the enables. The request line is gated by them. The global summary bit can therefore read 1 while the line stays low.

The line is a two-state machine. Its states are `LINE_IDLE` (request low) and `LINE_ACTIVE` (request high). The transition `RAISE` goes from `LINE_IDLE` to `LINE_ACTIVE` when the gating condition holds. The transition `DROP` goes from `LINE_ACTIVE` to `LINE_IDLE` when the condition fails. In any other case each state holds.

Top module: `aud_irq_agg`

## Requirements
- R1: Status bit 30 (controller) is set when `ring_sts & ring_ctl` has bit 0 (response interrupt) or bit 2 (ring overrun) set.
- R2: Status bit 30 is also set when any bit of `codec_chg` is 1 together with the same bit of `codec_wake`.
- R3: For stream i (byte i of `strm_sts`/`strm_ctl`, bits 8i+7..8i), status bit i is set when the status byte ANDed with the control byte has bit 2 (completion), bit 3 (FIFO error) or bit 4 (descriptor error) set.
- R4: Status bit 31 (global) is 1 exactly when any other status bit is 1. Status bits N_STREAMS..29 always read 0.
- R5: `irq` is 1 when `gctl[31]` (global enable) is 1 and the status AND `gctl` is nonzero in bit 30 (controller enable) or in any stream bit 0..N_STREAMS-1.
- R6: `irq` is 0 whenever the condition of R5 fails, even while status bit 31 is 1 (global enable clear, or active sources not enabled).
- R7: `status` and `irq` take the values implied by the inputs present before a rising clock edge, right after that edge. They hold their old values until then.
- R8: While `rst_n` is low, `status` is 0 and `irq` is 0, at once and independent of the clock.
- R9: Ring bits other than 0 and 2, and stream bits other than 2, 3 and 4, never set any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sts | input | 8 | Response-ring status flags |
| ring_ctl | input | 8 | Response-ring interrupt controls |
| codec_chg | input | CODEC_W | Codec state-change flags |
| codec_wake | input | CODEC_W | Per-codec wake enables |
| strm_sts | input | 8*N_STREAMS | Per-stream status bytes |
| strm_ctl | input | 8*N_STREAMS | Per-stream control bytes |
| gctl | input | 32 | Global control: bit 31 global enable, bit 30 controller enable, bits 0..N_STREAMS-1 stream enables |
| status | output | 32 | Aggregated status word |
| irq | output | 1 | Interrupt request level |

## Verification
Both `status` and `irq` are due exactly one rising edge after their inputs settle. Each stimulus is therefore driven on a falling edge and the outputs are sampled on the next falling edge. This puts the sample half a period after the edge that loads them. A directed latency test also samples before that edge to confirm that the old values still hold. The reset check samples shortly after `rst_n` falls, with no clock edge in between.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
    localparam int STS_W        = 32;
    localparam int GIS_BIT      = 31;
    localparam int CIS_BIT      = 30;
    localparam int RING_W       = 8;
    localparam int RING_RESP    = 0;
    localparam int RING_OVR     = 2;
    localparam int SBYTE_W      = 8;
    localparam int EV_DONE      = 2;
    localparam int EV_FIFO      = 3;
    localparam int EV_DESC      = 4;
    localparam logic [RING_W-1:0]  RING_MASK = (RING_W'(1) << RING_RESP) | (RING_W'(1) << RING_OVR);
    localparam logic [SBYTE_W-1:0] EV_MASK   = (SBYTE_W'(1) << EV_DONE) | (SBYTE_W'(1) << EV_FIFO)
                                             | (SBYTE_W'(1) << EV_DESC);

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_t;
endpackage

// File: rtl/aud_irq_ctl_src.sv
module aud_irq_ctl_src
    import aud_irq_pkg::*;
#(
    parameter int CODEC_W = 15
) (
    input  logic [RING_W-1:0]  ring_sts,
    input  logic [RING_W-1:0]  ring_ctl,
    input  logic [CODEC_W-1:0] codec_chg,
    input  logic [CODEC_W-1:0] codec_wake,
    output logic               ctl_hit
);
    logic ring_hit;
    logic wake_hit;

    always_comb begin
        ring_hit = |(ring_sts & ring_ctl & RING_MASK);
        wake_hit = |(codec_chg & codec_wake);
        ctl_hit  = ring_hit | wake_hit;
    end
endmodule

// File: rtl/aud_irq_strm_src.sv
module aud_irq_strm_src
    import aud_irq_pkg::*;
#(
    parameter int N_STREAMS = 8
) (
    input  logic [SBYTE_W*N_STREAMS-1:0] strm_sts,
    input  logic [SBYTE_W*N_STREAMS-1:0] strm_ctl,
    output logic [N_STREAMS-1:0]         strm_hit
);
    for (genvar gi = 0; gi < N_STREAMS; gi++) begin : g_strm
        logic [SBYTE_W-1:0] ev;
        always_comb begin
            ev           = strm_sts[gi*SBYTE_W +: SBYTE_W] & strm_ctl[gi*SBYTE_W +: SBYTE_W];
            strm_hit[gi] = |(ev & EV_MASK);
        end
    end
endmodule

// File: rtl/aud_irq_line.sv
module aud_irq_line
    import aud_irq_pkg::*;
#(
    parameter int N_STREAMS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] gctl,
    input  logic [STS_W-1:0] status_nxt,
    output logic             irq
);
    localparam logic [STS_W-1:0] STRM_EN = STS_W'((64'd1 << N_STREAMS) - 64'd1);
    localparam logic [STS_W-1:0] EN_MASK = STRM_EN | (STS_W'(1) << CIS_BIT);

    line_state_t state;
    line_state_t state_nxt;
    logic        want;

    always_comb begin
        want      = gctl[GIS_BIT] && (|(status_nxt & gctl & EN_MASK));
        state_nxt = state;
        unique case (state)
            LINE_IDLE:   if (want)  state_nxt = LINE_ACTIVE;  // RAISE
            LINE_ACTIVE: if (!want) state_nxt = LINE_IDLE;    // DROP
            default:     state_nxt = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LINE_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        irq = (state == LINE_ACTIVE);
    end

    // R6
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(gctl[GIS_BIT]));
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
    import aud_irq_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int CODEC_W   = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [RING_W-1:0]            ring_sts,
    input  logic [RING_W-1:0]            ring_ctl,
    input  logic [CODEC_W-1:0]           codec_chg,
    input  logic [CODEC_W-1:0]           codec_wake,
    input  logic [SBYTE_W*N_STREAMS-1:0] strm_sts,
    input  logic [SBYTE_W*N_STREAMS-1:0] strm_ctl,
    input  logic [STS_W-1:0]             gctl,
    output logic [STS_W-1:0]             status,
    output logic                         irq
);
    logic                 ctl_hit;
    logic [N_STREAMS-1:0] strm_hit;
    logic [STS_W-1:0]     status_nxt;

    aud_irq_ctl_src #(.CODEC_W(CODEC_W)) u_ctl (
        .ring_sts   (ring_sts),
        .ring_ctl   (ring_ctl),
        .codec_chg  (codec_chg),
        .codec_wake (codec_wake),
        .ctl_hit    (ctl_hit)
    );

    aud_irq_strm_src #(.N_STREAMS(N_STREAMS)) u_strm (
        .strm_sts (strm_sts),
        .strm_ctl (strm_ctl),
        .strm_hit (strm_hit)
    );

    always_comb begin
        status_nxt                = '0;
        status_nxt[N_STREAMS-1:0] = strm_hit;
        status_nxt[CIS_BIT]       = ctl_hit;
        status_nxt[GIS_BIT]       = ctl_hit | (|strm_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_nxt;
    end

    aud_irq_line #(.N_STREAMS(N_STREAMS)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .gctl       (gctl),
        .status_nxt (status_nxt),
        .irq        (irq)
    );

    // R4
    gis_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[GIS_BIT] == (|status[GIS_BIT-1:0]));
    // R5
    irq_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status[GIS_BIT]);
    // R1
    cis_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[CIS_BIT] |-> $past((|(ring_sts & ring_ctl & RING_MASK)) || (|(codec_chg & codec_wake))));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (status == '0) && !irq);

    for (genvar gi = 0; gi < N_STREAMS; gi++) begin : g_schk
        // R3
        strm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[gi] |-> $past(|(strm_sts[gi*SBYTE_W +: SBYTE_W] & strm_ctl[gi*SBYTE_W +: SBYTE_W] & EV_MASK)));
    end
endmodule

// File: tb/aud_irq_agg_test.sv
module aud_irq_agg_test;
    localparam int PERIOD = 10;
    localparam int NS = 8;
    localparam int CW = 15;
    localparam int NV = 13;

    typedef struct packed {
        logic [7:0]   rs;
        logic [7:0]   rc;
        logic [14:0]  cc;
        logic [14:0]  cw;
        logic [63:0]  ss;
        logic [63:0]  sc;
        logic [31:0]  g;
        logic [31:0]  es;
        logic         ei;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{8'h00, 8'h00, 15'h0000, 15'h0000, 64'h0, 64'h0, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{8'h01, 8'h01, 15'h0000, 15'h0000, 64'h0, 64'h0, 32'hC000_0000, 32'hC000_0000, 1'b1},
        '{8'h04, 8'h04, 15'h0000, 15'h0000, 64'h0, 64'h0, 32'h4000_0000, 32'hC000_0000, 1'b0},
        '{8'h02, 8'h02, 15'h0000, 15'h0000, 64'h0, 64'h0, 32'hC000_00FF, 32'h0000_0000, 1'b0},
        '{8'h01, 8'h04, 15'h0000, 15'h0000, 64'h0, 64'h0, 32'hC000_0000, 32'h0000_0000, 1'b0},
        '{8'h00, 8'h00, 15'h0010, 15'h0010, 64'h0, 64'h0, 32'hC000_0000, 32'hC000_0000, 1'b1},
        '{8'h00, 8'h00, 15'h0010, 15'h0020, 64'h0, 64'h0, 32'hC000_0000, 32'h0000_0000, 1'b0},
        '{8'h00, 8'h00, 15'h0000, 15'h0000, 64'h04, 64'h04, 32'h8000_0001, 32'h8000_0001, 1'b1},
        '{8'h00, 8'h00, 15'h0000, 15'h0000, 64'h0800_0000, 64'h0800_0000, 32'h8000_0001, 32'h8000_0008, 1'b0},
        '{8'h00, 8'h00, 15'h0000, 15'h0000, 64'h1000_0000_0000_0000, 64'h1000_0000_0000_0000, 32'h8000_0080, 32'h8000_0080, 1'b1},
        '{8'h00, 8'h00, 15'h0000, 15'h0000, 64'h0000_0100_0000_0000, 64'h0000_0100_0000_0000, 32'h8000_00FF, 32'h0000_0000, 1'b0},
        '{8'h00, 8'h00, 15'h0000, 15'h0000, 64'h001C_0000, 64'h0018_0000, 32'h0000_0004, 32'h8000_0004, 1'b0},
        '{8'h01, 8'h01, 15'h0000, 15'h0000, 64'h0400, 64'h0400, 32'h8000_0002, 32'hC000_0002, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  ring_sts = '0, ring_ctl = '0;
    logic [CW-1:0] codec_chg = '0, codec_wake = '0;
    logic [8*NS-1:0] strm_sts = '0, strm_ctl = '0;
    logic [31:0] gctl = '0;
    logic [31:0] status;
    logic        irq;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    aud_irq_agg #(.N_STREAMS(NS), .CODEC_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ring_sts(ring_sts), .ring_ctl(ring_ctl),
        .codec_chg(codec_chg), .codec_wake(codec_wake), .strm_sts(strm_sts),
        .strm_ctl(strm_ctl), .gctl(gctl), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] es, input logic ei);
        checks++;
        if (status !== es || irq !== ei) begin
            errors++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", req, status, irq, es, ei);
        end
    endtask

    task automatic apply(input vec_t v);
        ring_sts = v.rs; ring_ctl = v.rc; codec_chg = v.cc; codec_wake = v.cw;
        strm_sts = v.ss; strm_ctl = v.sc; gctl = v.g;
    endtask

    initial begin
        #(PERIOD*20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: status=%h irq=%b expected completion", status, irq);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R8: reset state with sources active
        ring_sts = 8'h01; ring_ctl = 8'h01; gctl = 32'hC000_0000;
        repeat (3) @(negedge clk);
        chk("R8 reset", 32'h0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 32'hC000_0000, 1'b1);

        // table: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            @(negedge clk);
            chk($sformatf("R1-table row %0d (R3 R4 R5 R6 R9)", i), TBL[i].es, TBL[i].ei);
        end

        // R7: old values hold until the next rising edge
        @(negedge clk);
        apply(TBL[0]);
        @(negedge clk);
        chk("R7 idle", 32'h0, 1'b0);
        apply(TBL[1]);
        #(PERIOD/2 - 1);
        chk("R7 before edge", 32'h0, 1'b0);
        #2;
        chk("R7 after edge", 32'hC000_0000, 1'b1);

        // R6: global enable removed drops line but keeps status
        @(negedge clk);
        gctl = 32'h4000_00FF;
        @(negedge clk);
        chk("R6 gie cleared", 32'hC000_0000, 1'b0);

        // R2: highest codec index
        @(negedge clk);
        apply(TBL[0]);
        codec_chg = 15'h4000; codec_wake = 15'h4000; gctl = 32'hC000_0000;
        @(negedge clk);
        chk("R2 top codec", 32'hC000_0000, 1'b1);

        // R3: all streams, all events, full enables
        @(negedge clk);
        apply(TBL[0]);
        strm_sts = {NS{8'h1C}}; strm_ctl = {NS{8'hFF}}; gctl = 32'h8000_00FF;
        @(negedge clk);
        chk("R3 all streams", 32'h8000_00FF, 1'b1);

        // R9: non-event stream bits ignored
        @(negedge clk);
        strm_sts = {NS{8'hE3}}; strm_ctl = {NS{8'hFF}};
        @(negedge clk);
        chk("R9 ignored stream bits", 32'h0, 1'b0);

        // R8: asynchronous reset mid-run
        @(negedge clk);
        strm_sts = {NS{8'h04}};
        @(negedge clk);
        chk("R3 before async reset", 32'h8000_00FF, 1'b1);
        #1 rst_n = 1'b0;
        #1;
        chk("R8 async reset", 32'h0, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule